// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor's store path and a direct-mapped data cache. A committed store is parked here as an address and one data word. The cache data array is not touched when the store is accepted. A load presents its address to an associative lookup in the same cycle. If any held entry has the same word address, the load receives that buffered word at once, and the cache need not supply data. When several entries match, the most recently accepted one wins.

In the background the buffer drains its oldest entry toward the cache, one per cycle. Draining is allowed only while the cache's miss machinery reports idle and no load lookup is being made in that cycle, so loads always take priority over draining. For each drain, the cache returns a combinational hit/miss answer. On a hit, the block issues a word write that carries the line index and word-in-line offset taken from the address. On a miss, it raises a miss-start pulse so the miss handler picks up the drained address and word. In both cases the entry leaves the buffer.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `ld_hit` is 0 and `drn_fire` is 0.
- R2: A store is accepted in a cycle where `st_valid` and `st_ready` are both 1. `st_ready` is 0 exactly when DEPTH entries are held, and a store offered then is dropped.
- R3: When `ld_valid` is 1 and at least one held entry has address bits [31:2] equal to those of `ld_addr`, `ld_hit` is 1 and `ld_data` is the word of the youngest such entry.
- R4: When no held entry matches, or the buffer is empty, `ld_hit` is 0.
- R5: `drn_fire` is 1 exactly when the buffer holds an entry, `miss_idle` is 1 and `ld_valid` is 0. The fired entry is the oldest held entry and is removed at the clock edge, so entries drain in acceptance order.
- R6: In any cycle with `ld_valid` at 1, no entry drains and the buffer contents are unchanged apart from an accepted store.
- R7: A drain with `drn_hit` at 1 raises `wr_en` with `wr_data` equal to the entry's word. `wr_woff` is address bits [3:2] and `wr_index` is address bits [IDX_W+3:4].
- R8: A drain with `drn_hit` at 0 raises `miss_start` instead of `wr_en`, with `drn_addr` and `drn_data` carrying the entry's full address and word.
- R9: Address bits [1:0] take no part in matching. A lookup that differs from a held store only in those bits still hits.
- R10: `wr_en` is never raised by accepting a store. It is raised only by a drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| st_valid | input | 1 | Store offered |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store word |
| st_ready | output | 1 | Buffer can accept a store |
| ld_valid | input | 1 | Load lookup this cycle |
| ld_addr | input | AW | Load byte address |
| ld_hit | output | 1 | A held entry matches the load |
| ld_data | output | DW | Word of the youngest matching entry |
| miss_idle | input | 1 | Cache miss machinery is idle |
| drn_hit | input | 1 | Cache hit answer for the drained address |
| drn_fire | output | 1 | Oldest entry drains this cycle |
| drn_addr | output | AW | Address of the oldest entry |
| drn_data | output | DW | Word of the oldest entry |
| wr_en | output | 1 | Word write into the cached line |
| wr_index | output | IDX_W | Line index of the write |
| wr_woff | output | 2 | Word offset within the line |
| miss_start | output | 1 | Drained entry missed; start the miss sequence |

## Verification
The bench uses the default DEPTH of 4 with 32-bit address and data and a 6-bit index. Because the depth is small, random store traffic reaches the full condition often, and the pointers wrap many times in a few thousand cycles. Addresses come from eight words spread over two lines, with random byte offsets. This makes duplicate matches, youngest-entry selection, byte-offset-insensitive matching, and both line indices common. Random `ld_valid` and `miss_idle` exercise drain blocking in every combination.

// File: rtl/stb_pkg.sv
package stb_pkg;
  // Outcome of one drain cycle.
  typedef enum logic [1:0] {
    DRN_NONE  = 2'd0,
    DRN_WRITE = 2'd1,
    DRN_MISS  = 2'd2
  } drn_kind_e;

  localparam int WORD_LSB = 2;  // byte offset bits below the word
  localparam int LINE_LSB = 4;  // 16-byte lines, 4 words
endpackage

// File: rtl/stb_fifo.sv
module stb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [AW-1:0] slot_addr [DEPTH],
  output logic [DW-1:0] slot_data [DEPTH],
  output logic [PW-1:0] rd_slot,
  output logic [CW-1:0] occupancy
);
  logic [CW-1:0] wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] rd_ptr_q, rd_ptr_d;
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic          do_push, do_pop;

  assign occupancy = wr_ptr_q - rd_ptr_q;
  assign full      = (occupancy == CW'(DEPTH));
  assign empty     = (occupancy == '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign rd_slot   = rd_ptr_q[PW-1:0];
  assign head_addr = addr_q[rd_slot];
  assign head_data = data_q[rd_slot];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (do_push) wr_ptr_d = wr_ptr_q + CW'(1);
    if (do_pop)  rd_ptr_d = rd_ptr_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  // Entry storage carries no reset; writes are clock-enabled per slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wen;
    assign wen = do_push && (wr_ptr_q[PW-1:0] == PW'(g));
    always_ff @(posedge clk) begin
      if (wen) begin
        addr_q[g] <= push_addr;
        data_q[g] <= push_data;
      end
    end
    assign slot_addr[g] = addr_q[g];
    assign slot_data[g] = data_q[g];
  end

  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(DEPTH));
  // R2
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/stb_search.sv
module stb_search #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic [AW-1:0] slot_addr [DEPTH],
  input  logic [DW-1:0] slot_data [DEPTH],
  input  logic [PW-1:0] rd_slot,
  input  logic [CW-1:0] occupancy,
  input  logic          q_valid,
  input  logic [AW-1:0] q_addr,
  output logic          q_hit,
  output logic [DW-1:0] q_data
);
  import stb_pkg::*;

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    logic [PW-1:0] s;
    q_hit  = 1'b0;
    q_data = '0;
    for (int age = 0; age < DEPTH; age++) begin
      s = rd_slot + PW'(age);
      if (q_valid && (CW'(age) < occupancy) &&
          (slot_addr[s][AW-1:WORD_LSB] == q_addr[AW-1:WORD_LSB])) begin
        q_hit  = 1'b1;
        q_data = slot_data[s];
      end
    end
  end
endmodule

// File: rtl/stb_drain.sv
module stb_drain #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 6
) (
  input  logic             have_entry,
  input  logic             miss_idle,
  input  logic             load_lock,
  input  logic             cache_hit,
  input  logic [AW-1:0]    head_addr,
  output logic             fire,
  output stb_pkg::drn_kind_e kind,
  output logic [IDX_W-1:0] index,
  output logic [1:0]       woff
);
  import stb_pkg::*;

  // A load in this cycle locks the cache port against the drain.
  assign fire  = have_entry && miss_idle && !load_lock;
  assign index = head_addr[LINE_LSB +: IDX_W];
  assign woff  = head_addr[LINE_LSB-1:WORD_LSB];

  always_comb begin
    kind = DRN_NONE;
    if (fire) kind = cache_hit ? DRN_WRITE : DRN_MISS;
  end
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 6,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic [AW-1:0]    st_addr,
  input  logic [DW-1:0]    st_data,
  output logic             st_ready,
  input  logic             ld_valid,
  input  logic [AW-1:0]    ld_addr,
  output logic             ld_hit,
  output logic [DW-1:0]    ld_data,
  input  logic             miss_idle,
  input  logic             drn_hit,
  output logic             drn_fire,
  output logic [AW-1:0]    drn_addr,
  output logic [DW-1:0]    drn_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_index,
  output logic [1:0]       wr_woff,
  output logic             miss_start
);
  import stb_pkg::*;

  logic          full, empty;
  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];
  logic [PW-1:0] rd_slot;
  logic [CW-1:0] occupancy;
  drn_kind_e     kind;

  stb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_valid),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (drn_fire),
    .full      (full),
    .empty     (empty),
    .head_addr (drn_addr),
    .head_data (drn_data),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .rd_slot   (rd_slot),
    .occupancy (occupancy)
  );

  stb_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .rd_slot   (rd_slot),
    .occupancy (occupancy),
    .q_valid   (ld_valid),
    .q_addr    (ld_addr),
    .q_hit     (ld_hit),
    .q_data    (ld_data)
  );

  stb_drain #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_drain (
    .have_entry (!empty),
    .miss_idle  (miss_idle),
    .load_lock  (ld_valid),
    .cache_hit  (drn_hit),
    .head_addr  (drn_addr),
    .fire       (drn_fire),
    .kind       (kind),
    .index      (wr_index),
    .woff       (wr_woff)
  );

  assign st_ready   = !full;
  assign wr_en      = (kind == DRN_WRITE);
  assign miss_start = (kind == DRN_MISS);

  // R5
  drain_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drn_fire |-> !empty);
  // R6
  load_blocks_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !drn_fire);
  // R5
  busy_miss_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_idle |-> !drn_fire);
  // R8
  write_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_en, miss_start}) <= 1);
  // R4
  empty_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !ld_hit);
endmodule

// File: tb/store_fwd_buffer_test.sv
module store_fwd_buffer_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int IDX_W  = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid, ld_valid, miss_idle, drn_hit;
  logic [31:0] st_addr, st_data, ld_addr;
  logic st_ready, ld_hit, drn_fire, wr_en, miss_start;
  logic [31:0] ld_data, drn_addr, drn_data;
  logic [IDX_W-1:0] wr_index;
  logic [1:0] wr_woff;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] qa[$];
  logic [31:0] qd[$];

  always #(PERIOD/2) clk = ~clk;

  store_fwd_buffer #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare all outputs against the queue model, then advance the model.
  task automatic step;
    logic eh; logic [31:0] ed; logic ef;
    #1;
    eh = 1'b0; ed = '0;
    if (ld_valid)
      foreach (qa[i])
        if (qa[i][31:2] == ld_addr[31:2]) begin eh = 1'b1; ed = qd[i]; end
    ef = (qa.size() > 0) && miss_idle && !ld_valid;
    chk("R2", "st_ready", 32'(st_ready), 32'(qa.size() < DEPTH));
    chk(eh ? "R3" : "R4", "ld_hit", 32'(ld_hit), 32'(eh));
    if (eh) chk("R3", "ld_data", ld_data, ed);
    chk(ld_valid ? "R6" : "R5", "drn_fire", 32'(drn_fire), 32'(ef));
    chk("R7", "wr_en", 32'(wr_en), 32'(ef && drn_hit));
    chk("R8", "miss_start", 32'(miss_start), 32'(ef && !drn_hit));
    if (ef) begin
      chk("R5", "drn_addr", drn_addr, qa[0]);
      chk("R8", "drn_data", drn_data, qd[0]);
      if (drn_hit) begin
        chk("R7", "wr_index", 32'(wr_index), 32'(qa[0][IDX_W+3:4]));
        chk("R7", "wr_woff", 32'(wr_woff), 32'(qa[0][3:2]));
      end
      void'(qa.pop_front()); void'(qd.pop_front());
    end
    if (st_valid && (qa.size() + (ef ? 1 : 0)) < DEPTH) begin
      qa.push_back(st_addr); qd.push_back(st_data);
    end
  endtask

  task automatic drive(input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                       input logic lv, input logic [31:0] la,
                       input logic mi, input logic dh);
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd;
    ld_valid = lv; ld_addr = la; miss_idle = mi; drn_hit = dh;
    step();
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    st_valid = 0; ld_valid = 0; miss_idle = 1; drn_hit = 0;
    st_addr = '0; st_data = '0; ld_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "st_ready", 32'(st_ready), 32'd1);
    chk("R1", "ld_hit", 32'(ld_hit), 32'd0);
    chk("R1", "drn_fire", 32'(drn_fire), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2: fill past full with drain held off; R10: no writes on accept
    for (int k = 0; k < DEPTH + 2; k++) begin
      drive(1, 32'h0000_0040, 32'hA000_0000 + 32'(k), 0, '0, 0, 1);
      chk("R10", "wr_en on store", 32'(wr_en), 32'd0);
    end
    // R3 youngest of duplicates, R9 differing byte offset
    drive(0, '0, '0, 1, 32'h0000_0043, 1, 1);
    chk("R9", "ld_hit byte offset", 32'(ld_hit), 32'd1);
    chk("R3", "youngest", ld_data, 32'hA000_0003);
    // R4 miss on other word
    drive(0, '0, '0, 1, 32'h0000_0044, 1, 1);
    // R5 drain in order with a mix of hit and miss
    for (int k = 0; k < DEPTH + 1; k++) drive(0, '0, '0, 0, '0, 1, k[0]);
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] a, b;
      a = 32'h1000_0000 | (($urandom % 8) << 2) | ($urandom % 4);
      b = 32'h1000_0000 | (($urandom % 8) << 2) | ($urandom % 4);
      drive(($urandom % 3) != 0, a, $urandom, ($urandom % 3) == 0, b,
            ($urandom % 4) != 0, $urandom % 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule